// File: doc/BRIEF.md
# Enable-Gated Duplex FIFO Pair with Level Interrupts

This block holds two 16-bit data queues between a processor register port and a serial front-end link. The processor pushes words into the transmit queue and the link pulls them out. The link pushes words into the receive queue and the processor pulls them out. All four data paths are valid/ready streams. Each direction has its own enable input that gates the link side and the interrupt requests. The transmit queue may be preloaded while its enable is low.

Interrupt requests are combinational level outputs, one per condition, each with its own enable bit in `irq_mask`. Transmit raises a request when it is empty and when its fill level is at or below a shared threshold. Receive raises a request when it is full and when its fill level is at or above the same threshold. Back-pressure rules: a transmit write is taken only in a cycle where `cpu_tx_ready` is high. A receive push is taken only where `link_rx_ready` is high. Neither edge stalls a producer. A processor write offered while `cpu_tx_ready` is low is discarded and marks transmit overflow. A link push offered while the receiver is enabled and full is discarded and marks receive overflow. A push offered while the receiver is disabled is discarded silently. The consuming sides (`link_tx_*`, `cpu_rx_*`) follow plain valid/ready, and `*_valid` never depends on `*_ready`.

Top module: `duplex_fifo_pair`

## Requirements
- R1: Each queue stores up to DEPTH (default 128) words of DATA_W (default 16) bits, returns them in arrival order, and reports its fill count on `tx_level`/`rx_level` (0 to DEPTH).
- R2: `cpu_tx_ready` is high whenever the transmit queue is not full, whatever `tx_en` is. Each accepted beat raises `tx_level` by one on the next cycle, so data can be preloaded while `tx_en` is 0.
- R3: `link_tx_valid` is high only when `tx_en` is 1 and `tx_level` > 0. `link_tx_data` shows the oldest word, and a handshake removes it. Nothing drains while `tx_en` is 0.
- R4: In the cycle `tx_en` goes from 1 to 0, the transmit queue restarts from its first entry, and `tx_level` reads 0 on the next cycle. A write offered in that same cycle becomes the only stored word (level 1).
- R5: `link_rx_ready` equals `rx_en` AND not full. While `rx_en` is 0, pushes are ignored, `rx_level` stays 0 and no overflow is flagged.
- R6: `cpu_rx_valid` is high only when `rx_en` is 1 and `rx_level` > 0, with the oldest word on `cpu_rx_data`. Whenever `rx_en` is 0, the receive queue is emptied by the next cycle and held empty.
- R7: `irq_tx_empty` = `irq_mask[0]` AND `tx_en` AND (`tx_level` == 0). It is combinational, so raising `tx_en` on an empty queue raises the request in the same cycle.
- R8: `irq_tx_thr` = `irq_mask[1]` AND `tx_en` AND (`tx_level` <= `thresh`).
- R9: `irq_rx_full` = `irq_mask[2]` AND `rx_en` AND (`rx_level` == DEPTH).
- R10: `irq_rx_thr` = `irq_mask[3]` AND `rx_en` AND (`rx_level` >= `thresh`) AND (`rx_level` > 0).
- R11: A discarded transmit write sets `tx_ovf`, and a discarded enabled receive push sets `rx_ovf`. Each flag holds until a one-cycle pulse on `tx_ovf_clr`/`rx_ovf_clr`. A new discard in the same cycle as a clear pulse wins, and the flag stays set.
- R12: `link_tx_data` is all zeros whenever `link_tx_valid` is low, including right after reset.
- R13: After reset, both levels are 0, both overflow flags are 0 and all four requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| thresh | input | 7 | Shared fill threshold (log2 DEPTH bits) |
| irq_mask | input | 4 | Request enables: bit0 tx empty, bit1 tx threshold, bit2 rx full, bit3 rx threshold |
| cpu_tx_valid | input | 1 | Processor write strobe |
| cpu_tx_data | input | 16 | Processor write word |
| cpu_tx_ready | output | 1 | Transmit queue can accept a word |
| link_tx_valid | output | 1 | Transmit word available to link |
| link_tx_ready | input | 1 | Link takes transmit word |
| link_tx_data | output | 16 | Oldest transmit word, zero when idle |
| link_rx_valid | input | 1 | Link receive push strobe |
| link_rx_data | input | 16 | Link receive word |
| link_rx_ready | output | 1 | Receive queue can accept a word |
| cpu_rx_valid | output | 1 | Receive word available to processor |
| cpu_rx_ready | input | 1 | Processor takes receive word |
| cpu_rx_data | output | 16 | Oldest receive word |
| tx_level | output | 8 | Transmit fill count |
| rx_level | output | 8 | Receive fill count |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_ovf_clr | input | 1 | Clear pulse for tx_ovf |
| rx_ovf_clr | input | 1 | Clear pulse for rx_ovf |
| irq_tx_empty | output | 1 | Transmit empty request |
| irq_tx_thr | output | 1 | Transmit threshold request |
| irq_rx_full | output | 1 | Receive full request |
| irq_rx_thr | output | 1 | Receive threshold request |

## Verification
The transmit restart is the hardest case to reach from the ports. It needs a falling `tx_en` edge while words are stored, with a processor write offered in that exact cycle. The bench builds a partly filled queue with the link stalled and drops the enable together with a write strobe. It then re-enables and drains to confirm that only the new word survives. Each fill level from empty to full is also swept against every threshold value in a small DEPTH=8 instance, so the boundary comparisons at equality and at the extremes are all covered.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  localparam int IRQ_TX_EMPTY = 0;
  localparam int IRQ_TX_THR   = 1;
  localparam int IRQ_RX_FULL  = 2;
  localparam int IRQ_RX_THR   = 3;
  localparam int IRQ_COUNT    = 4;

  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } fill_dir_e;
endpackage

// File: rtl/dfp_fifo_core.sv
module dfp_fifo_core #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              push, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);
  // a restart frees every slot, so a write in that cycle always lands
  assign push  = wr_en && (!full || restart);
  assign pop   = rd_en && !empty && !restart;
  assign rd_data = store[rptr];

  always_ff @(posedge clk) begin
    if (push) store[restart ? '0 : wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (restart) begin
      rptr  <= '0;
      wptr  <= push ? PTR_W'(1) : '0;
      level <= push ? CNT_W'(1) : '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/dfp_level_irq.sv
module dfp_level_irq
  import dfp_pkg::*;
#(
  parameter int        DEPTH = 128,
  parameter fill_dir_e DIR   = DIR_DRAIN,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             en,
  input  logic [CNT_W-1:0] level,
  input  logic [THR_W-1:0] thresh,
  input  logic             edge_mask,
  input  logic             thr_mask,
  output logic             irq_edge,
  output logic             irq_thr
);
  logic [CNT_W-1:0] thr_ext;
  logic             edge_hit, thr_hit;

  assign thr_ext = CNT_W'(thresh);

  generate
    if (DIR == DIR_FILL) begin : g_fill
      assign edge_hit = (level == CNT_W'(DEPTH));
      assign thr_hit  = (level >= thr_ext) && (level != '0);
    end else begin : g_drain
      assign edge_hit = (level == '0);
      assign thr_hit  = (level <= thr_ext);
    end
  endgenerate

  assign irq_edge = en && edge_mask && edge_hit;
  assign irq_thr  = en && thr_mask && thr_hit;
endmodule

// File: rtl/dfp_sticky_flag.sv
module dfp_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/duplex_fifo_pair.sv
module duplex_fifo_pair
  import dfp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 rx_en,
  input  logic [THR_W-1:0]     thresh,
  input  logic [IRQ_COUNT-1:0] irq_mask,
  input  logic                 cpu_tx_valid,
  input  logic [DATA_W-1:0]    cpu_tx_data,
  output logic                 cpu_tx_ready,
  output logic                 link_tx_valid,
  input  logic                 link_tx_ready,
  output logic [DATA_W-1:0]    link_tx_data,
  input  logic                 link_rx_valid,
  input  logic [DATA_W-1:0]    link_rx_data,
  output logic                 link_rx_ready,
  output logic                 cpu_rx_valid,
  input  logic                 cpu_rx_ready,
  output logic [DATA_W-1:0]    cpu_rx_data,
  output logic [CNT_W-1:0]     tx_level,
  output logic [CNT_W-1:0]     rx_level,
  output logic                 tx_ovf,
  output logic                 rx_ovf,
  input  logic                 tx_ovf_clr,
  input  logic                 rx_ovf_clr,
  output logic                 irq_tx_empty,
  output logic                 irq_tx_thr,
  output logic                 irq_rx_full,
  output logic                 irq_rx_thr
);
  logic              tx_en_q, tx_restart;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] tx_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_en_q <= 1'b0;
    else        tx_en_q <= tx_en;
  end
  assign tx_restart = tx_en_q && !tx_en;

  // transmit direction
  dfp_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst_n(rst_n), .restart(tx_restart),
    .wr_en(cpu_tx_valid), .wr_data(cpu_tx_data),
    .rd_en(link_tx_valid && link_tx_ready), .rd_data(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );
  assign cpu_tx_ready  = !tx_full || tx_restart;
  assign link_tx_valid = tx_en && !tx_empty;
  assign link_tx_data  = link_tx_valid ? tx_head : '0;

  // receive direction: disabled means held at the first entry
  dfp_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst_n(rst_n), .restart(!rx_en),
    .wr_en(link_rx_valid && rx_en), .wr_data(link_rx_data),
    .rd_en(cpu_rx_valid && cpu_rx_ready), .rd_data(cpu_rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );
  assign link_rx_ready = rx_en && !rx_full;
  assign cpu_rx_valid  = rx_en && !rx_empty;

  dfp_sticky_flag tx_ovf_i (
    .clk(clk), .rst_n(rst_n),
    .set(cpu_tx_valid && !cpu_tx_ready), .clr(tx_ovf_clr), .q(tx_ovf)
  );
  dfp_sticky_flag rx_ovf_i (
    .clk(clk), .rst_n(rst_n),
    .set(link_rx_valid && rx_en && rx_full), .clr(rx_ovf_clr), .q(rx_ovf)
  );

  dfp_level_irq #(.DEPTH(DEPTH), .DIR(DIR_DRAIN)) tx_irq_i (
    .en(tx_en), .level(tx_level), .thresh(thresh),
    .edge_mask(irq_mask[IRQ_TX_EMPTY]), .thr_mask(irq_mask[IRQ_TX_THR]),
    .irq_edge(irq_tx_empty), .irq_thr(irq_tx_thr)
  );
  dfp_level_irq #(.DEPTH(DEPTH), .DIR(DIR_FILL)) rx_irq_i (
    .en(rx_en), .level(rx_level), .thresh(thresh),
    .edge_mask(irq_mask[IRQ_RX_FULL]), .thr_mask(irq_mask[IRQ_RX_THR]),
    .irq_edge(irq_rx_full), .irq_thr(irq_rx_thr)
  );
endmodule

// File: rtl/dfp_pair_checker.sv
module dfp_pair_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic [3:0]        irq_mask,
  input logic              cpu_tx_valid,
  input logic              cpu_tx_ready,
  input logic              link_tx_valid,
  input logic              link_tx_ready,
  input logic [DATA_W-1:0] link_tx_data,
  input logic              link_rx_valid,
  input logic              link_rx_ready,
  input logic              cpu_rx_valid,
  input logic [CNT_W-1:0]  tx_level,
  input logic [CNT_W-1:0]  rx_level,
  input logic              tx_ovf,
  input logic              tx_ovf_clr,
  input logic              irq_tx_empty
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));

  a_r2_tx_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && cpu_tx_valid && cpu_tx_ready && !(link_tx_valid && link_tx_ready))
    |=> (tx_level == $past(tx_level) + CNT_W'(1)));

  a_r3_no_drain_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !link_tx_valid);

  a_r4_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && tx_en) ##1 !tx_en |=> (tx_level <= CNT_W'(1)));

  a_r5_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == CNT_W'(DEPTH)) |-> !link_rx_ready);

  a_r6_rx_held_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rx_level == '0) && !cpu_rx_valid);

  a_r7_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && irq_mask[0] && (tx_level == '0)) |-> irq_tx_empty);

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_ovf_clr) |=> tx_ovf);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !link_tx_valid |-> (link_tx_data == '0));
endmodule

bind duplex_fifo_pair dfp_pair_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .irq_mask(irq_mask),
  .cpu_tx_valid(cpu_tx_valid), .cpu_tx_ready(cpu_tx_ready),
  .link_tx_valid(link_tx_valid), .link_tx_ready(link_tx_ready),
  .link_tx_data(link_tx_data), .link_rx_valid(link_rx_valid),
  .link_rx_ready(link_rx_ready), .cpu_rx_valid(cpu_rx_valid),
  .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf),
  .tx_ovf_clr(tx_ovf_clr), .irq_tx_empty(irq_tx_empty)
);

// File: tb/duplex_fifo_pair_tb_top.sv
module duplex_fifo_pair_tb_top;
  localparam int DW = 16;
  localparam int DEP = 8;
  localparam int TW = $clog2(DEP);
  localparam int CW = $clog2(DEP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic [TW-1:0] thresh = '0;
  logic [3:0] irq_mask = 4'hF;
  logic cpu_tx_valid = 1'b0, link_tx_ready = 1'b0;
  logic link_rx_valid = 1'b0, cpu_rx_ready = 1'b0;
  logic [DW-1:0] cpu_tx_data = '0, link_rx_data = '0;
  logic tx_ovf_clr = 1'b0, rx_ovf_clr = 1'b0;
  logic cpu_tx_ready, link_tx_valid, link_rx_ready, cpu_rx_valid;
  logic [DW-1:0] link_tx_data, cpu_rx_data;
  logic [CW-1:0] tx_level, rx_level;
  logic tx_ovf, rx_ovf, irq_tx_empty, irq_tx_thr, irq_rx_full, irq_rx_thr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  duplex_fifo_pair #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .thresh(thresh),
    .irq_mask(irq_mask), .cpu_tx_valid(cpu_tx_valid), .cpu_tx_data(cpu_tx_data),
    .cpu_tx_ready(cpu_tx_ready), .link_tx_valid(link_tx_valid),
    .link_tx_ready(link_tx_ready), .link_tx_data(link_tx_data),
    .link_rx_valid(link_rx_valid), .link_rx_data(link_rx_data),
    .link_rx_ready(link_rx_ready), .cpu_rx_valid(cpu_rx_valid),
    .cpu_rx_ready(cpu_rx_ready), .cpu_rx_data(cpu_rx_data),
    .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
    .tx_ovf_clr(tx_ovf_clr), .rx_ovf_clr(rx_ovf_clr),
    .irq_tx_empty(irq_tx_empty), .irq_tx_thr(irq_tx_thr),
    .irq_rx_full(irq_rx_full), .irq_rx_thr(irq_rx_thr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push_tx(input logic [DW-1:0] d);
    cpu_tx_valid = 1'b1;
    cpu_tx_data  = d;
    step();
    cpu_tx_valid = 1'b0;
  endtask

  task automatic push_rx(input logic [DW-1:0] d);
    link_rx_valid = 1'b1;
    link_rx_data  = d;
    step();
    link_rx_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R13 reset state, R12 idle data
    chk("R13 tx_level", int'(tx_level), 0);
    chk("R13 rx_level", int'(rx_level), 0);
    chk("R13 ovf", int'({tx_ovf, rx_ovf}), 0);
    chk("R13 irqs", int'({irq_tx_empty, irq_tx_thr, irq_rx_full, irq_rx_thr}), 0);
    chk("R12 idle data after reset", int'(link_tx_data), 0);

    // R7: enabling an empty transmit queue raises the request at once
    tx_en = 1'b1;
    #1;
    chk("R7 empty irq on enable", int'(irq_tx_empty), 1);
    step();
    // R2/R3: preload while disabled, link ready but no drain
    tx_en = 1'b0;
    link_tx_ready = 1'b1;
    step();
    push_tx(16'hC000);
    push_tx(16'hC001);
    step();
    chk("R2 preload level", int'(tx_level), 2);
    chk("R3 no valid while disabled", int'(link_tx_valid), 0);
    chk("R7 no empty irq while disabled", int'(irq_tx_empty), 0);
    tx_en = 1'b1;
    #1;
    chk("R3 head word", int'(link_tx_data), 16'hC000);
    step();
    chk("R3 second word", int'(link_tx_data), 16'hC001);
    step();
    chk("R3 drained", int'(tx_level), 0);
    link_tx_ready = 1'b0;

    // R8/R7/R2 sweep every level against every threshold
    for (int n = 0; n <= DEP; n++) begin
      for (int t = 0; t < DEP; t++) begin
        thresh = TW'(t);
        #1;
        chk("R8 tx threshold irq", int'(irq_tx_thr), (n <= t) ? 1 : 0);
      end
      chk("R1 tx level", int'(tx_level), n);
      chk("R7 tx empty irq", int'(irq_tx_empty), (n == 0) ? 1 : 0);
      chk("R2 tx ready", int'(cpu_tx_ready), (n < DEP) ? 1 : 0);
      if (n < DEP) push_tx(DW'(16'hA000 + n));
    end

    // R11 overflow on transmit
    push_tx(16'hDEAD);
    chk("R11 tx ovf set", int'(tx_ovf), 1);
    chk("R11 full level unchanged", int'(tx_level), DEP);
    tx_ovf_clr = 1'b1;
    step();
    tx_ovf_clr = 1'b0;
    chk("R11 tx ovf cleared", int'(tx_ovf), 0);
    tx_ovf_clr = 1'b1;
    push_tx(16'hDEAD);
    tx_ovf_clr = 1'b0;
    chk("R11 set wins over clear", int'(tx_ovf), 1);
    tx_ovf_clr = 1'b1;
    step();
    tx_ovf_clr = 1'b0;

    // R1/R3 drain in order
    link_tx_ready = 1'b1;
    for (int i = 0; i < DEP; i++) begin
      #1;
      chk("R3 drain valid", int'(link_tx_valid), 1);
      chk("R1 drain order", int'(link_tx_data), 16'hA000 + i);
      step();
    end
    link_tx_ready = 1'b0;
    chk("R12 idle data after drain", int'(link_tx_data), 0);
    chk("R3 valid low when empty", int'(link_tx_valid), 0);

    // R4 restart with a write in the falling-enable cycle
    push_tx(16'hA100);
    push_tx(16'hA101);
    push_tx(16'hA102);
    tx_en = 1'b0;
    push_tx(16'hBEEF);
    chk("R4 level after restart", int'(tx_level), 1);
    tx_en = 1'b1;
    link_tx_ready = 1'b1;
    #1;
    chk("R4 surviving word", int'(link_tx_data), 16'hBEEF);
    step();
    link_tx_ready = 1'b0;
    chk("R4 queue empty after one", int'(tx_level), 0);

    // R5 pushes ignored while receiver disabled
    link_rx_valid = 1'b1;
    link_rx_data  = 16'h1111;
    #1;
    chk("R5 rx ready low disabled", int'(link_rx_ready), 0);
    step();
    link_rx_valid = 1'b0;
    chk("R5 rx level stays 0", int'(rx_level), 0);
    chk("R5 no ovf when disabled", int'(rx_ovf), 0);

    // R9/R10 sweep
    rx_en = 1'b1;
    for (int n = 0; n <= DEP; n++) begin
      for (int t = 0; t < DEP; t++) begin
        thresh = TW'(t);
        #1;
        chk("R10 rx threshold irq", int'(irq_rx_thr), (n >= t && n > 0) ? 1 : 0);
      end
      chk("R1 rx level", int'(rx_level), n);
      chk("R9 rx full irq", int'(irq_rx_full), (n == DEP) ? 1 : 0);
      chk("R5 rx ready", int'(link_rx_ready), (n < DEP) ? 1 : 0);
      if (n < DEP) push_rx(DW'(16'h5000 + n));
    end
    push_rx(16'hDEAD);
    chk("R11 rx ovf set", int'(rx_ovf), 1);
    rx_ovf_clr = 1'b1;
    step();
    rx_ovf_clr = 1'b0;
    chk("R11 rx ovf cleared", int'(rx_ovf), 0);

    // masks gate all requests (tx empty+enabled, rx full)
    irq_mask = 4'h0;
    thresh = TW'(3);
    #1;
    chk("R7 masked", int'(irq_tx_empty), 0);
    chk("R8 masked", int'(irq_tx_thr), 0);
    chk("R9 masked", int'(irq_rx_full), 0);
    chk("R10 masked", int'(irq_rx_thr), 0);
    irq_mask = 4'hF;

    // R6 read out in order
    cpu_rx_ready = 1'b1;
    for (int i = 0; i < DEP; i++) begin
      #1;
      chk("R6 rx valid", int'(cpu_rx_valid), 1);
      chk("R6 rx order", int'(cpu_rx_data), 16'h5000 + i);
      step();
    end
    cpu_rx_ready = 1'b0;
    chk("R6 rx empty", int'(cpu_rx_valid), 0);
    push_rx(16'h6000);
    push_rx(16'h6001);
    push_rx(16'h6002);
    rx_en = 1'b0;
    step();
    chk("R6 disable empties rx", int'(rx_level), 0);
    chk("R6 no valid disabled", int'(cpu_rx_valid), 0);
    chk("R10 no irq disabled", int'(irq_rx_thr), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule